// File: doc/BRIEF.md
# Dual-channel inductor current slope sign detector

This block watches two streams of sampled inductor current, one for each stage of a two-stage converter run from one shared carrier. Each stream arrives as a signed two's-complement word, qualified by a common sample strobe. For every strobed sample, each channel compares the new value against the value it received four strobed samples before. It then reports one bit: whether the current is rising or falling. The size of the slope is never produced.

A downstream switch fault monitor checks the two bits together. The block therefore also gives their logical AND, which is high only when both stage currents climb at once. A validity flag stays low until the look-back windows hold enough history for the first real comparison.

All outputs are registered. They change only on clock edges where the strobe is high.

Top module: `islope_sign`

## Requirements
- R1: After reset, `sign_a`, `sign_b`, `sign_and` and `sign_ok` are all 0.
- R2: On a strobed sample, once the window is full, a channel's sign bit becomes 1 when the new sample is greater than the sample taken exactly four strobed samples earlier.
- R3: On a strobed sample, once the window is full, a channel's sign bit becomes 0 when the new sample is less than the sample taken four strobed samples earlier.
- R4: `sign_and` always equals the AND of `sign_a` and `sign_b` as updated on the same edge.
- R5: On cycles where `smp_vld` is low, no output changes and no sample enters the look-back window. The four-sample distance therefore counts strobed samples only.
- R6: `sign_ok` is 0 for the first four strobed samples after reset. It becomes 1 with the fifth, which is the first comparison, and then stays 1 until the next reset.
- R7: When the new sample equals the sample four strobed samples earlier, that channel keeps its previous sign bit. Before the first comparison, that previous bit is the reset value 0.
- R8: The comparison is signed two's-complement. For example, -1 compared with -5 is rising, and 3 compared with -2 is rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe for both channels |
| cur_a | input | W | Stage-one current sample, signed |
| cur_b | input | W | Stage-two current sample, signed |
| sign_a | output | 1 | Stage-one slope sign (1 = rising) |
| sign_b | output | 1 | Stage-two slope sign (1 = rising) |
| sign_and | output | 1 | AND of the two sign bits |
| sign_ok | output | 1 | Sign outputs carry a real comparison |

## Verification
Each result belongs to the clock edge on which its strobed sample is taken. All four outputs are visible from that same edge, one register after the inputs.

The bench applies a sample half a period before an edge. It updates its own model of the window and sign bits at that edge, and compares the outputs 1 ns after it, well clear of the next edge. Cycles with the strobe low are checked the same way, to show that the outputs hold. Those idle cycles also shift nothing in the bench's window, so later comparisons show whether the design skipped them as well.

// File: rtl/islope_sign.sv
module islope_sign #(
  parameter int W   = 16,
  parameter int LAG = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_vld,
  input  logic signed [W-1:0] cur_a,
  input  logic signed [W-1:0] cur_b,
  output logic                sign_a,
  output logic                sign_b,
  output logic                sign_and,
  output logic                sign_ok
);

  localparam int CW = $clog2(LAG + 1);

  logic signed [W-1:0] dly_a [LAG];
  logic signed [W-1:0] dly_b [LAG];
  logic [CW-1:0]       fill;
  logic                full;
  logic                nxt_a, nxt_b;

  assign full = (fill == CW'(LAG));

  always_comb begin
    nxt_a = sign_a;
    nxt_b = sign_b;
    if (smp_vld && full) begin
      if (cur_a > dly_a[LAG-1])      nxt_a = 1'b1;
      else if (cur_a < dly_a[LAG-1]) nxt_a = 1'b0;
      if (cur_b > dly_b[LAG-1])      nxt_b = 1'b1;
      else if (cur_b < dly_b[LAG-1]) nxt_b = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LAG; i++) begin
        dly_a[i] <= '0;
        dly_b[i] <= '0;
      end
      fill     <= '0;
      sign_a   <= 1'b0;
      sign_b   <= 1'b0;
      sign_and <= 1'b0;
      sign_ok  <= 1'b0;
    end else if (smp_vld) begin
      dly_a[0] <= cur_a;
      dly_b[0] <= cur_b;
      for (int i = 1; i < LAG; i++) begin
        dly_a[i] <= dly_a[i-1];
        dly_b[i] <= dly_b[i-1];
      end
      if (!full) fill <= fill + CW'(1);
      else       sign_ok <= 1'b1;
      sign_a   <= nxt_a;
      sign_b   <= nxt_b;
      sign_and <= nxt_a & nxt_b;
    end
  end

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(sign_a) && $stable(sign_b) && $stable(sign_and) && $stable(sign_ok));

  p_and_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sign_and == (sign_a & sign_b));

  p_ok_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sign_ok |=> sign_ok);

  p_rise_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && full && cur_a > dly_a[LAG-1]) |=> sign_a);

  p_fall_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && full && cur_b < dly_b[LAG-1]) |=> !sign_b);

  p_equal_hold_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && full && cur_a == dly_a[LAG-1]) |=> $stable(sign_a));

endmodule

// File: tb/test_islope_sign.sv
`timescale 1ns/1ps
module test_islope_sign;

  logic clk = 1'b0;
  logic rst_n;
  logic smp_vld;
  logic signed [15:0] cur_a, cur_b;
  logic sign_a, sign_b, sign_and, sign_ok;

  int n_chk = 0;
  int n_err = 0;

  int  ha [4];
  int  hb [4];
  int  fillm;
  bit  ea, eb, eok;

  always #2.5 clk = ~clk;

  islope_sign #(.W(16), .LAG(4)) i_islope_sign (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
    .cur_a(cur_a), .cur_b(cur_b),
    .sign_a(sign_a), .sign_b(sign_b), .sign_and(sign_and), .sign_ok(sign_ok)
  );

  function automatic bit nsign(int now, int old, bit prev);
    if (now > old) return 1'b1;
    if (now < old) return 1'b0;
    return prev;
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(int a, int b, bit v, string req);
    @(negedge clk);
    cur_a = 16'(a); cur_b = 16'(b); smp_vld = v;
    @(posedge clk);
    #1;
    if (v) begin
      if (fillm == 4) begin
        ea  = nsign(a, ha[3], ea);
        eb  = nsign(b, hb[3], eb);
        eok = 1'b1;
      end
      for (int i = 3; i > 0; i--) begin
        ha[i] = ha[i-1];
        hb[i] = hb[i-1];
      end
      ha[0] = a; hb[0] = b;
      if (fillm < 4) fillm++;
    end
    chk(req, "sign_a", sign_a, ea);
    chk(req, "sign_b", sign_b, eb);
    chk("R4", "sign_and", sign_and, ea & eb);
    chk("R6", "sign_ok", sign_ok, eok);
  endtask

  initial begin
    #(5.0 * 200000);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b0; smp_vld = 1'b0; cur_a = '0; cur_b = '0;
    fillm = 0; ea = 0; eb = 0; eok = 0;
    for (int i = 0; i < 4; i++) begin ha[i] = 0; hb[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "sign_a", sign_a, 1'b0);
    chk("R1", "sign_b", sign_b, 1'b0);
    chk("R1", "sign_and", sign_and, 1'b0);
    chk("R1", "sign_ok", sign_ok, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // R6 fill: first four strobed samples give no comparison; R7 equal on first compare keeps 0
    step(10, 10, 1, "R6");
    step(20, 20, 1, "R6");
    step(30, 30, 1, "R6");
    step(40, 40, 1, "R6");
    step(10, 10, 1, "R7");
    // R2 rising against 4-back (20), not 3-back (30)
    step(25, 25, 1, "R2");
    // R5 idle cycles with wild inputs must not shift or change outputs
    step(-30000, 30000, 0, "R5");
    step(30000, -30000, 0, "R5");
    // 4-back is 30 (idle cycles skipped): 29 falls
    step(29, 31, 1, "R3");
    // R7 equal with 4-back (40): hold previous
    step(40, 40, 1, "R7");
    // R8 signed: build negative history
    step(-5, -2, 1, "R8");
    step(-4, -2, 1, "R8");
    step(-3, -2, 1, "R8");
    step(-2, -2, 1, "R8");
    step(-1, 3, 1, "R8");
    step(-6, -3, 1, "R8");
    step(-32768, 32767, 1, "R8");
    step(-32768, -32768, 1, "R3");
    // random mix with frequent equality and idle cycles
    for (int k = 0; k < 3000; k++) begin
      int a, b;
      bit v;
      if ($urandom_range(0, 3) == 0) begin
        a = int'($urandom_range(0, 6)) - 3;
        b = int'($urandom_range(0, 6)) - 3;
      end else begin
        a = int'($urandom_range(0, 65535)) - 32768;
        b = int'($urandom_range(0, 65535)) - 32768;
      end
      v = ($urandom_range(0, 4) != 0);
      step(a, b, v, v ? "R2" : "R5");
    end
    // reset again mid-stream
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    chk("R1", "sign_ok", sign_ok, 1'b0);
    chk("R1", "sign_a", sign_a, 1'b0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule